// File: doc/BRIEF.md
# Single-Error-Correcting Data Memory

This block is a small on-chip data store, 128 bytes by default, that keeps a Hamming check field beside every byte. A byte presented on the write port is encoded into a 12-bit codeword and stored on the rising clock edge. The read address is captured on the same edge. The stored codeword at that address then goes through a combinational syndrome decoder, which repairs any single flipped bit before the byte reaches the output. A read therefore has the same cycle timing as a plain synchronous memory. The decoder adds only gate depth.

A read made with the read enable high raises an error flag when the decoder sees a nonzero syndrome. The repaired byte is still returned. The repair acts only on the output path, so a damaged word stays damaged in storage until the same address is written again.

A fault-injection port lets a test environment or a radiation-effects campaign invert one chosen bit of one stored codeword, so that the correction path can be exercised on demand.

Top module: `ecc_ram`

## Requirements
- R1: When `wr_en` is high at a rising edge, the codeword of `wr_data` is stored at `wr_addr`. Any earlier fault in that word is discarded.
- R2: `rd_addr` is captured at each rising edge, and `rd_data` shows the corrected byte at that address right after the same edge. A write to that address on the same edge is already visible.
- R3: A read of a word with no flipped bit returns the written byte, with `rd_err` low.
- R4: With exactly one of the 12 stored bits inverted, a read still returns the written byte. This holds whichever bit is inverted, check bit or data bit. `rd_err` is high if `rd_en` was high at the capturing edge.
- R5: `rd_err` is low after any edge at which `rd_en` was low. `rd_data` is still the corrected byte in that case.
- R6: When `inj_en` is high at an edge, stored bit `inj_bit` of word `inj_addr` is inverted. Codeword bit k carries Hamming position k+1. The check bits sit at bits 0, 1, 3 and 7, and data bits 0 to 7 sit at bits 2, 4, 5, 6, 8, 9, 10 and 11. An `inj_bit` of 12 or more changes nothing. Inverting the same bit twice restores the word.
- R7: An injected fault persists through any number of reads. It is cleared only by a write to that address.
- R8: When a write and an injection hit the same address on the same edge, the new codeword is stored with the chosen bit inverted. When they hit different addresses, both take effect.
- R9: During and after reset, with no read requested, `rd_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the read-side registers |
| wr_en | input | 1 | Write request |
| wr_addr | input | 7 | Write word address |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read request; qualifies the error flag |
| rd_addr | input | 7 | Read word address, captured at the edge |
| rd_data | output | 8 | Corrected byte of the captured address |
| rd_err | output | 1 | Nonzero syndrome seen on a requested read |
| inj_en | input | 1 | Fault-injection request |
| inj_addr | input | 7 | Word to damage |
| inj_bit | input | 4 | Codeword bit to invert |

## Verification
The interesting overlap is a write and a fault injection aimed at the same word on the same clock edge. This decides whether the fault lands on the old or the new codeword. A directed step writes a fresh byte and injects into that address at once. A later read must return the new byte with the flag raised, and a plain rewrite must then clear the flag. The random phase keeps most addresses in a narrow window so that such collisions, and reads of the word being written, occur often. A bench model applies the write first and then the bit flip, and judges every cycle's byte and flag against that model.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

   // smallest check-bit count p with 2**p >= data + p + 1
   function automatic int chk_bits(input int dw);
      int p;
      p = 0;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
   import ecc_ram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CW_W   = 12
) (
   input  logic [DATA_W-1:0] data,
   output logic [CW_W-1:0]   cw
);

   always_comb begin
      logic [CW_W-1:0] w;
      logic            par;
      int              j;
      w   = '0;
      j   = 0;
      par = 1'b0;
      // scatter data over non-power-of-two positions
      for (int pos = 1; pos <= CW_W; pos++) begin
         if (!is_pow2(pos) && j < DATA_W) begin
            w[pos-1] = data[j];
            j++;
         end
      end
      // each check bit covers the positions that share its bit
      for (int pos = 1; pos <= CW_W; pos++) begin
         if (is_pow2(pos)) begin
            par = 1'b0;
            for (int q = 1; q <= CW_W; q++)
               if (((q & pos) != 0) && (q != pos)) par ^= w[q-1];
            w[pos-1] = par;
         end
      end
      cw = w;
   end

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
   import ecc_ram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   parameter int CW_W   = 12
) (
   input  logic [CW_W-1:0]   cw,
   output logic [DATA_W-1:0] data,
   output logic              syn_nz
);

   logic [CHK_W-1:0] syn;
   logic [CW_W-1:0]  fixed;

   always_comb begin
      syn = '0;
      for (int pos = 1; pos <= CW_W; pos++)
         if (cw[pos-1]) syn ^= CHK_W'(pos);
   end

   always_comb begin
      int j;
      fixed = cw;
      for (int pos = 1; pos <= CW_W; pos++)
         if (int'(syn) == pos) fixed[pos-1] = ~cw[pos-1];
      data = '0;
      j    = 0;
      for (int pos = 1; pos <= CW_W; pos++) begin
         if (!is_pow2(pos) && j < DATA_W) begin
            data[j] = fixed[pos-1];
            j++;
         end
      end
   end

   assign syn_nz = (syn != '0);

endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
   parameter int CW_W   = 12,
   parameter int DEPTH  = 128,
   parameter int ADDR_W = 7,
   parameter int BIT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CW_W-1:0]   wr_cw,
   input  logic              inj_en,
   input  logic [ADDR_W-1:0] inj_addr,
   input  logic [BIT_W-1:0]  inj_bit,
   input  logic [ADDR_W-1:0] rd_addr_q,
   output logic [CW_W-1:0]   rd_cw
);

   logic [CW_W-1:0] mem [DEPTH];
   logic [CW_W-1:0] fmask;
   logic [CW_W-1:0] inj_base;

   // out-of-range bit index yields an empty mask
   for (genvar b = 0; b < CW_W; b++) begin : g_mask
      assign fmask[b] = (int'(inj_bit) == b);
   end

   // a same-edge write is the word the fault lands on
   assign inj_base = (wr_en && wr_addr == inj_addr) ? wr_cw : mem[inj_addr];

   always_ff @(posedge clk) begin
      if (wr_en)  mem[wr_addr]  <= wr_cw;
      if (inj_en) mem[inj_addr] <= inj_base ^ fmask;
   end

   assign rd_cw = mem[rd_addr_q];

   assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(inj_en && inj_addr == wr_addr)) |=> mem[$past(wr_addr)] == $past(wr_cw));

   assert_inject_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_en && !wr_en && int'(inj_bit) < CW_W)
      |=> $countones(mem[$past(inj_addr)] ^ $past(mem[inj_addr])) == 1);

   assert_collision_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_en && wr_en && inj_addr == wr_addr && int'(inj_bit) < CW_W)
      |=> $countones(mem[$past(wr_addr)] ^ $past(wr_cw)) == 1);

endmodule

// File: rtl/ecc_ram.sv
module ecc_ram
   import ecc_ram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 128,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CHK_W  = chk_bits(DATA_W),
   localparam int CW_W   = DATA_W + CHK_W,
   localparam int BIT_W  = $clog2(CW_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   input  logic              inj_en,
   input  logic [ADDR_W-1:0] inj_addr,
   input  logic [BIT_W-1:0]  inj_bit
);

   if (DATA_W < 2) begin : g_bad_width
      $error("ecc_ram: DATA_W must be at least 2");
   end
   if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("ecc_ram: DEPTH must be a power of two");
   end

   logic [ADDR_W-1:0] rd_addr_q;
   logic              rd_en_q;
   logic [CW_W-1:0]   wr_cw;
   logic [CW_W-1:0]   rd_cw;
   logic              syn_nz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr_q <= '0;
         rd_en_q   <= 1'b0;
      end else begin
         rd_addr_q <= rd_addr;
         rd_en_q   <= rd_en;
      end
   end

   ecc_enc #(.DATA_W(DATA_W), .CW_W(CW_W)) u_enc (
      .data (wr_data),
      .cw   (wr_cw)
   );

   ecc_store #(.CW_W(CW_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_cw     (wr_cw),
      .inj_en    (inj_en),
      .inj_addr  (inj_addr),
      .inj_bit   (inj_bit),
      .rd_addr_q (rd_addr_q),
      .rd_cw     (rd_cw)
   );

   ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_dec (
      .cw     (rd_cw),
      .data   (rd_data),
      .syn_nz (syn_nz)
   );

   assign rd_err = rd_en_q & syn_nz;

   assert_flag_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_err);

   assert_same_edge_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && rd_addr == wr_addr && !inj_en)
      |=> (rd_data == $past(wr_data)) && !rd_err);

   always_comb begin
      if (!rst_n) assert_reset_quiet_R9: assert (!rd_err);
   end

endmodule

// File: tb/sim_ecc_ram.sv
`timescale 1ns/1ps
module sim_ecc_ram;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, rd_en, inj_en;
   logic [6:0] wr_addr, rd_addr, inj_addr;
   logic [7:0] wr_data;
   logic [3:0] inj_bit;
   logic [7:0] rd_data;
   logic       rd_err;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [7:0]  m_data  [128];
   logic [11:0] m_fault [128];

   always #5 clk = ~clk;

   ecc_ram u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_err(rd_err),
      .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit)
   );

   task automatic chk(input string tag, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // one clock: drive, clock, update model (write before flip), compare
   task automatic step(input string tag,
                       input logic we, input logic [6:0] wa, input logic [7:0] wd,
                       input logic re, input logic [6:0] ra,
                       input logic ie, input logic [6:0] ia, input logic [3:0] ib);
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_en = re; rd_addr = ra;
      inj_en = ie; inj_addr = ia; inj_bit = ib;
      @(posedge clk);
      #1;
      if (we) begin
         m_data[wa]  = wd;
         m_fault[wa] = '0;
      end
      if (ie && ib < 12) m_fault[ia] ^= 12'(1) << ib;
      chk(tag, "data", int'(rd_data), int'(m_data[ra]));
      chk(tag, "err",  int'(rd_err),  int'(re && (m_fault[ra] != '0)));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      wr_en = 0; rd_en = 0; inj_en = 0;
      wr_addr = 0; rd_addr = 0; inj_addr = 0; wr_data = 0; inj_bit = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R9", "err in reset", int'(rd_err), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R9", "err after reset", int'(rd_err), 0);

      // R1 R2: fill every word, reading the word written on the same edge
      for (int a = 0; a < 128; a++)
         step("R2", 1, 7'(a), 8'(a * 37 + 11), 1, 7'(a), 0, 0, 0);
      // R3: clean read-back
      for (int a = 0; a < 128; a += 9)
         step("R3", 0, 0, 0, 1, 7'(a), 0, 0, 0);

      // R4 R7 R6: every bit position on word 5, flagged, persistent, then undone
      for (int b = 0; b < 12; b++) begin
         step("R6", 0, 0, 0, 0, 0, 1, 7'd5, 4'(b));
         step("R4", 0, 0, 0, 1, 7'd5, 0, 0, 0);
         step("R7", 0, 0, 0, 1, 7'd5, 0, 0, 0);
         step("R6", 0, 0, 0, 1, 7'd5, 1, 7'd5, 4'(b));
      end
      // R6: out-of-range bit index leaves the word intact
      step("R6", 0, 0, 0, 0, 0, 1, 7'd6, 4'd13);
      step("R6", 0, 0, 0, 1, 7'd6, 1, 7'd6, 4'd15);
      step("R6", 0, 0, 0, 1, 7'd6, 0, 0, 0);
      // R5: damaged word read without enable
      step("R5", 0, 0, 0, 0, 0, 1, 7'd9, 4'd8);
      step("R5", 0, 0, 0, 0, 7'd9, 0, 0, 0);
      step("R5", 0, 0, 0, 1, 7'd9, 0, 0, 0);
      // R7: rewrite clears the stored fault
      step("R7", 1, 7'd9, 8'hA5, 1, 7'd9, 0, 0, 0);
      step("R7", 0, 0, 0, 1, 7'd9, 0, 0, 0);
      // R8: write and inject same word, same edge
      step("R8", 1, 7'd20, 8'h3C, 0, 0, 1, 7'd20, 4'd2);
      step("R8", 0, 0, 0, 1, 7'd20, 0, 0, 0);
      step("R8", 1, 7'd20, 8'hC3, 1, 7'd20, 0, 0, 0);
      // R8: different words, both applied
      step("R8", 1, 7'd21, 8'h5A, 0, 0, 1, 7'd22, 4'd0);
      step("R8", 0, 0, 0, 1, 7'd21, 0, 0, 0);
      step("R8", 0, 0, 0, 1, 7'd22, 0, 0, 0);

      // random mix, fixed seed, narrow address window for collisions
      void'($urandom(32'd20240607));
      for (int n = 0; n < 4000; n++) begin
         logic       we, re, ie;
         logic [6:0] wa, ra, ia;
         logic [7:0] wd;
         logic [3:0] ib;
         we = ($urandom % 3) == 0;
         re = ($urandom % 4) != 0;
         ie = ($urandom % 4) == 0;
         wa = ($urandom % 2) ? 7'($urandom % 8) : 7'($urandom);
         ra = ($urandom % 2) ? 7'($urandom % 8) : 7'($urandom);
         ia = 7'($urandom % 8);
         wd = 8'($urandom);
         ib = 4'($urandom);
         // keep each word at most one bit from clean: reuse its existing flip
         if (ie && ib < 12 && !(we && wa == ia) && m_fault[ia] != '0)
            for (int b = 0; b < 12; b++)
               if (m_fault[ia][b]) ib = 4'(b);
         step("R4", we, wa, wd, re, ra, ie, ia, ib);
      end

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule